// File: doc/BRIEF.md
# MDIO Pseudo-PHY Paged Register Sequencer

This block turns one host request for a wide switch register (1, 2, 4, 6 or 8 bytes, named by an 8-bit page and an 8-bit register offset) into a chain of 16-bit management transfers. Every transfer goes to a single fixed PHY address. The block selects the page when needed, stages write data, issues the command, polls for completion and gathers read data.

The management master is reached through a request/acknowledge pair. The block raises `mdio_req` with the PHY address, register number, write data and a read flag, and holds them steady. The master answers with a one-cycle `mdio_ack`, together with `mdio_rdata` for reads. Bit-level MDIO framing belongs to that master.

The page last written is cached so that repeated accesses to one page skip the page-select transfer. The cache is empty after reset. One request is served at a time.

Top module: `mdio_paged_seq`

## Requirements
- R1: Every transfer uses PHY address 0x1E. `mdio_req` and its address, data and read flag stay unchanged until the acknowledge cycle, and `mdio_req` is low in the cycle after an acknowledge.
- R2: When no page is cached, or the requested page differs from the cached one, the first transfer writes register 0x10 with the page in bits 15:8 and 0x01 in bits 7:0. When the page matches, that transfer is skipped.
- R3: A write first stages data registers from the highest index down to 0x18. Lengths 1 and 2 use 0x18 only, length 4 uses 0x19 and 0x18, length 6 also uses 0x1A, and length 8 also uses 0x1B. Register 0x18+k receives write-data bits 16k+15:16k, and bytes beyond the length are sent as zero.
- R4: The command is a write of register 0x11 with the register offset in bits 15:8, zeros in bits 7:2 and the opcode in bits 1:0 (1 for write, 2 for read).
- R5: After the command, register 0x11 is read repeatedly until its bits 1:0 are both zero. Other bits are ignored. A write then finishes with a `done` pulse.
- R6: If `MAX_POLLS` (default 100) consecutive polls all show a busy value, the access ends with an `err_tmo` pulse and no data register is read. The page stays cached.
- R7: After a read completes, the data registers for the length are read from the highest index down to 0x18. `rdata` gets register 0x18 at bits 15:0, 0x19 at 31:16, and so on, with bytes beyond the length zero (length 1 gives only the low byte of 0x18). `rdata` changes only with the `done` of a read.
- R8: A length other than 1, 2, 4, 6 or 8 raises `err_len` for one cycle, in the cycle after acceptance. `busy` stays low and no transfer occurs.
- R9: `busy` is high from the cycle after a legal request is accepted until the cycle in which `done` or `err_tmo` pulses, and is low in that cycle. `done`, `err_len` and `err_tmo` are single-cycle pulses, at most one at a time. `req_valid` is ignored while `busy` is high.
- R10: After reset, `busy`, `done`, `err_len`, `err_tmo` and `mdio_req` are low and the page cache is empty, so the first request writes the page even when the page is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 for write, 0 for read |
| req_page | input | 8 | Switch register page |
| req_reg | input | 8 | Register offset within the page |
| req_len | input | 4 | Access length in bytes |
| req_wdata | input | 64 | Write data, little-endian |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Request finished successfully (pulse) |
| err_len | output | 1 | Illegal length rejected (pulse) |
| err_tmo | output | 1 | Completion poll timed out (pulse) |
| rdata | output | 64 | Read result, valid from a read's done |
| mdio_req | output | 1 | Management transfer request |
| mdio_phy | output | 5 | PHY address of the transfer |
| mdio_reg | output | 5 | Management register number |
| mdio_wdata | output | 16 | Write data of the transfer |
| mdio_rd | output | 1 | 1 for a read transfer |
| mdio_ack | input | 1 | Transfer complete (one cycle) |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |

## Verification
The properties assume that the management master raises `mdio_ack` only while `mdio_req` is high, for exactly one cycle, with `mdio_rdata` valid in that cycle. They also assume the host holds `req_*` stable during the cycle `req_valid` is sampled. The bench responder acknowledges only a pending request and drops the acknowledge at the next falling edge. The host side drives requests for one cycle between edges, and pokes `req_valid` only to test that a request is ignored while `busy` is high. The busy-poll counts given to the responder cover an immediate idle answer, a few busy answers, and a stall longer than `MAX_POLLS`.

// File: rtl/mdpp_pkg.sv
package mdpp_pkg;

    localparam int unsigned DW       = 16;
    localparam int unsigned NSLOT    = 4;
    localparam int unsigned RDW      = DW * NSLOT;

    localparam logic [4:0] REG_PAGE  = 5'h10;
    localparam logic [4:0] REG_CMD   = 5'h11;
    localparam logic [4:0] REG_DATA0 = 5'h18;

    localparam logic [1:0] OP_WR     = 2'd1;
    localparam logic [1:0] OP_RD     = 2'd2;

    typedef enum logic [2:0] {
        ST_PAGE,
        ST_WDATA,
        ST_CMD,
        ST_POLL,
        ST_RDATA
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_XFER,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic           write;
        logic [7:0]     page;
        logic [7:0]     regad;
        logic [3:0]     len;
        logic [1:0]     last;
        logic [RDW-1:0] wdata;
    } job_t;

    function automatic logic len_ok(input logic [3:0] len);
        return (len == 4'd1) || (len == 4'd2) || (len == 4'd4) ||
               (len == 4'd6) || (len == 4'd8);
    endfunction

    function automatic logic [1:0] len_last(input logic [3:0] len);
        case (len)
            4'd4:    return 2'd1;
            4'd6:    return 2'd2;
            4'd8:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [RDW-1:0] len_mask(input logic [3:0] len);
        logic [RDW-1:0] m;
        m = '0;
        for (int b = 0; b < RDW / 8; b++) begin
            if (b < int'(len)) m[b*8 +: 8] = 8'hFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/mdpp_decode.sv
module mdpp_decode
    import mdpp_pkg::*;
(
    input  logic [3:0]     len,
    input  logic [RDW-1:0] wdata,
    output logic           legal,
    output logic [1:0]     last,
    output logic [RDW-1:0] wdata_masked
);
    always_comb begin
        legal        = len_ok(len);
        last         = len_last(len);
        wdata_masked = wdata & len_mask(len);
    end
endmodule

// File: rtl/mdpp_collect.sv
module mdpp_collect
    import mdpp_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           cap,
    input  logic [1:0]     cap_idx,
    input  logic [DW-1:0]  din,
    input  logic           commit,
    input  logic [3:0]     len,
    output logic [RDW-1:0] rdata
);
    logic [DW-1:0]  slot [NSLOT];
    logic [RDW-1:0] merged;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr)
                slot[g] <= '0;
            else if (cap && cap_idx == 2'(g))
                slot[g] <= din;
        end
        assign merged[g*DW +: DW] = (cap && cap_idx == 2'(g)) ? din : slot[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (commit)
            rdata <= merged & len_mask(len);
    end
endmodule

// File: rtl/mdpp_fsm.sv
module mdpp_fsm
    import mdpp_pkg::*;
#(
    parameter int unsigned MAX_POLLS = 100,
    parameter logic [4:0]  PHY_ADDR  = 5'h1E
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [7:0]     req_page,
    input  logic [7:0]     req_reg,
    input  logic [3:0]     req_len,
    input  logic           legal,
    input  logic [1:0]     last,
    input  logic [RDW-1:0] wdata_masked,
    output logic           busy,
    output logic           done,
    output logic           err_len,
    output logic           err_tmo,
    output logic           mdio_req,
    output logic [4:0]     mdio_phy,
    output logic [4:0]     mdio_reg,
    output logic [DW-1:0]  mdio_wdata,
    output logic           mdio_rd,
    input  logic           mdio_ack,
    input  logic [1:0]     poll_bits,
    output logic           clr,
    output logic           cap,
    output logic [1:0]     cap_idx,
    output logic           commit,
    output logic [3:0]     job_len
);
    localparam int unsigned PW = $clog2(MAX_POLLS + 1);

    phase_e         phase;
    step_e          step;
    logic [1:0]     idx;
    logic [PW-1:0]  polls;
    logic           page_ok;
    logic [7:0]     page_q;
    job_t           job;
    logic           accept;
    logic           hit;

    assign accept = (phase == PH_IDLE) && req_valid;
    assign hit    = page_ok && (page_q == req_page);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            step    <= ST_PAGE;
            idx     <= '0;
            polls   <= '0;
            page_ok <= 1'b0;
            page_q  <= '0;
            job     <= '0;
            done    <= 1'b0;
            err_len <= 1'b0;
            err_tmo <= 1'b0;
        end else begin
            done    <= 1'b0;
            err_len <= 1'b0;
            err_tmo <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        if (!legal) begin
                            err_len <= 1'b1;
                        end else begin
                            job.write <= req_write;
                            job.page  <= req_page;
                            job.regad <= req_reg;
                            job.len   <= req_len;
                            job.last  <= last;
                            job.wdata <= wdata_masked;
                            phase     <= PH_XFER;
                            if (!hit) begin
                                step <= ST_PAGE;
                            end else if (req_write) begin
                                step <= ST_WDATA;
                                idx  <= last;
                            end else begin
                                step <= ST_CMD;
                            end
                        end
                    end
                end
                PH_GAP: phase <= PH_XFER;
                PH_XFER: begin
                    if (mdio_ack) begin
                        phase <= PH_GAP;
                        unique case (step)
                            ST_PAGE: begin
                                page_ok <= 1'b1;
                                page_q  <= job.page;
                                if (job.write) begin
                                    step <= ST_WDATA;
                                    idx  <= job.last;
                                end else begin
                                    step <= ST_CMD;
                                end
                            end
                            ST_WDATA: begin
                                if (idx == 2'd0) step <= ST_CMD;
                                else             idx  <= idx - 2'd1;
                            end
                            ST_CMD: begin
                                step  <= ST_POLL;
                                polls <= '0;
                            end
                            ST_POLL: begin
                                if (poll_bits == 2'b00) begin
                                    if (job.write) begin
                                        phase <= PH_IDLE;
                                        done  <= 1'b1;
                                    end else begin
                                        step <= ST_RDATA;
                                        idx  <= job.last;
                                    end
                                end else if (polls == PW'(MAX_POLLS - 1)) begin
                                    phase   <= PH_IDLE;
                                    err_tmo <= 1'b1;
                                end else begin
                                    polls <= polls + PW'(1);
                                end
                            end
                            ST_RDATA: begin
                                if (idx == 2'd0) begin
                                    phase <= PH_IDLE;
                                    done  <= 1'b1;
                                end else begin
                                    idx <= idx - 2'd1;
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        mdio_req   = (phase == PH_XFER);
        mdio_phy   = PHY_ADDR;
        mdio_reg   = REG_CMD;
        mdio_wdata = '0;
        mdio_rd    = 1'b0;
        unique case (step)
            ST_PAGE: begin
                mdio_reg   = REG_PAGE;
                mdio_wdata = {job.page, 8'h01};
            end
            ST_WDATA: begin
                mdio_reg   = REG_DATA0 + {3'b000, idx};
                mdio_wdata = job.wdata[{idx, 4'b0000} +: DW];
            end
            ST_CMD: begin
                mdio_wdata = {job.regad, 6'b000000, (job.write ? OP_WR : OP_RD)};
            end
            ST_POLL: begin
                mdio_rd = 1'b1;
            end
            ST_RDATA: begin
                mdio_reg = REG_DATA0 + {3'b000, idx};
                mdio_rd  = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy    = (phase != PH_IDLE);
    assign clr     = accept && legal;
    assign cap     = (phase == PH_XFER) && (step == ST_RDATA) && mdio_ack;
    assign cap_idx = idx;
    assign commit  = cap && (idx == 2'd0);
    assign job_len = job.len;
endmodule

// File: rtl/mdio_paged_seq.sv
module mdio_paged_seq
    import mdpp_pkg::*;
#(
    parameter int unsigned MAX_POLLS = 100,
    parameter logic [4:0]  PHY_ADDR  = 5'h1E
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_page,
    input  logic [7:0]  req_reg,
    input  logic [3:0]  req_len,
    input  logic [63:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        err_len,
    output logic        err_tmo,
    output logic [63:0] rdata,
    output logic        mdio_req,
    output logic [4:0]  mdio_phy,
    output logic [4:0]  mdio_reg,
    output logic [15:0] mdio_wdata,
    output logic        mdio_rd,
    input  logic        mdio_ack,
    input  logic [15:0] mdio_rdata
);
    logic           legal;
    logic [1:0]     last;
    logic [RDW-1:0] wdata_masked;
    logic           clr;
    logic           cap;
    logic [1:0]     cap_idx;
    logic           commit;
    logic [3:0]     job_len;

    mdpp_decode u_dec (
        .len          (req_len),
        .wdata        (req_wdata),
        .legal        (legal),
        .last         (last),
        .wdata_masked (wdata_masked)
    );

    mdpp_fsm #(
        .MAX_POLLS (MAX_POLLS),
        .PHY_ADDR  (PHY_ADDR)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_page     (req_page),
        .req_reg      (req_reg),
        .req_len      (req_len),
        .legal        (legal),
        .last         (last),
        .wdata_masked (wdata_masked),
        .busy         (busy),
        .done         (done),
        .err_len      (err_len),
        .err_tmo      (err_tmo),
        .mdio_req     (mdio_req),
        .mdio_phy     (mdio_phy),
        .mdio_reg     (mdio_reg),
        .mdio_wdata   (mdio_wdata),
        .mdio_rd      (mdio_rd),
        .mdio_ack     (mdio_ack),
        .poll_bits    (mdio_rdata[1:0]),
        .clr          (clr),
        .cap          (cap),
        .cap_idx      (cap_idx),
        .commit       (commit),
        .job_len      (job_len)
    );

    mdpp_collect u_col (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .cap     (cap),
        .cap_idx (cap_idx),
        .din     (mdio_rdata),
        .commit  (commit),
        .len     (job_len),
        .rdata   (rdata)
    );
endmodule

// File: rtl/mdpp_chk.sv
module mdpp_chk #(
    parameter logic [4:0] PHY_ADDR = 5'h1E
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err_len,
    input logic        err_tmo,
    input logic [63:0] rdata,
    input logic        mdio_req,
    input logic [4:0]  mdio_phy,
    input logic [4:0]  mdio_reg,
    input logic [15:0] mdio_wdata,
    input logic        mdio_rd,
    input logic        mdio_ack
);
    p_phy_fixed_r1: assert property (@(posedge clk) disable iff (rst)
        mdio_req |-> mdio_phy == PHY_ADDR);

    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_reg) &&
                                     $stable(mdio_wdata) && $stable(mdio_rd)));

    p_req_gap_r1: assert property (@(posedge clk) disable iff (rst)
        mdio_ack |=> !mdio_req);

    p_len_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        err_len |-> (!busy && !mdio_req));

    p_req_in_busy_r9: assert property (@(posedge clk) disable iff (rst)
        mdio_req |-> busy);

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err_len, err_tmo}));

    p_end_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (done || err_tmo) |-> !busy);

    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done || $stable(rdata)));
endmodule

bind mdio_paged_seq mdpp_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .err_len    (err_len),
    .err_tmo    (err_tmo),
    .rdata      (rdata),
    .mdio_req   (mdio_req),
    .mdio_phy   (mdio_phy),
    .mdio_reg   (mdio_reg),
    .mdio_wdata (mdio_wdata),
    .mdio_rd    (mdio_rd),
    .mdio_ack   (mdio_ack)
);

// File: tb/tb_mdio_paged_seq.sv
`timescale 1ns/1ps
module tb_mdio_paged_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [7:0]  req_page, req_reg;
    logic [3:0]  req_len;
    logic [63:0] req_wdata;
    logic        busy, done, err_len, err_tmo;
    logic [63:0] rdata;
    logic        mdio_req, mdio_rd, mdio_ack;
    logic [4:0]  mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata, mdio_rdata;

    always #2.5 clk = ~clk;

    mdio_paged_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_page(req_page), .req_reg(req_reg), .req_len(req_len),
        .req_wdata(req_wdata), .busy(busy), .done(done), .err_len(err_len),
        .err_tmo(err_tmo), .rdata(rdata), .mdio_req(mdio_req),
        .mdio_phy(mdio_phy), .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
        .mdio_rd(mdio_rd), .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata)
    );

    typedef struct {
        bit          rd;
        logic [4:0]  rg;
        logic [15:0] wd;
        string       tag;
    } xact_t;

    xact_t       expq[$];
    int          vectors = 0;
    int          fails   = 0;
    int          busy_left = 0;
    int          bpage = -1;
    logic [15:0] dregs [4];

    task automatic fail(input string msg);
        fails++;
        $display("FAIL %s", msg);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // responder + monitor: compares every transfer against the expected queue
    initial begin
        mdio_ack   = 1'b0;
        mdio_rdata = '0;
        forever begin
            @(negedge clk);
            if (mdio_ack) begin
                mdio_ack = 1'b0;
            end else if (mdio_req) begin
                vectors++;
                if (expq.size() == 0) begin
                    fail($sformatf("R1 unexpected transfer: actual rd=%0b reg=%h expected none",
                                   mdio_rd, mdio_reg));
                end else begin
                    xact_t e;
                    e = expq.pop_front();
                    if (mdio_phy != 5'h1E || mdio_rd != e.rd || mdio_reg != e.rg ||
                        (!e.rd && mdio_wdata != e.wd))
                        fail($sformatf("%s transfer: actual phy=%h rd=%0b reg=%h wd=%h expected phy=1e rd=%0b reg=%h wd=%h",
                                       e.tag, mdio_phy, mdio_rd, mdio_reg, mdio_wdata,
                                       e.rd, e.rg, e.wd));
                end
                if (mdio_rd && mdio_reg == 5'h11) begin
                    if (busy_left > 0) begin
                        busy_left--;
                        mdio_rdata = 16'h3001;
                    end else begin
                        mdio_rdata = 16'h3000;
                    end
                end else if (mdio_rd && mdio_reg >= 5'h18 && mdio_reg <= 5'h1B) begin
                    mdio_rdata = dregs[mdio_reg - 5'h18];
                end else begin
                    mdio_rdata = 16'h0000;
                end
                mdio_ack = 1'b1;
            end
        end
    end

    function automatic int last_of(input int len);
        return (len == 8) ? 3 : (len == 6) ? 2 : (len == 4) ? 1 : 0;
    endfunction

    function automatic logic [63:0] mask_of(input int len);
        logic [63:0] m = '0;
        for (int b = 0; b < len && b < 8; b++) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic run(input bit wr, input logic [7:0] pg, input logic [7:0] rg,
                       input int len, input logic [63:0] wd, input int nbusy,
                       input bit poke);
        bit          legal;
        bit          tmo;
        int          npoll;
        int          cyc;
        logic [63:0] wm;
        logic [63:0] exp_rd;
        logic [63:0] prev_rd;
        legal = (len == 1 || len == 2 || len == 4 || len == 6 || len == 8);
        tmo   = legal && (nbusy >= 100);
        wm    = wd & mask_of(len);
        prev_rd = rdata;
        if (legal) begin
            if (bpage != int'(pg)) expq.push_back('{0, 5'h10, {pg, 8'h01}, "R2"});
            bpage = int'(pg);
            if (wr)
                for (int k = last_of(len); k >= 0; k--)
                    expq.push_back('{0, 5'(8'h18 + k), wm[k*16 +: 16], "R3"});
            expq.push_back('{0, 5'h11, {rg, 6'b0, (wr ? 2'b01 : 2'b10)}, "R4"});
            npoll = tmo ? 100 : nbusy + 1;
            for (int p = 0; p < npoll; p++)
                expq.push_back('{1, 5'h11, 16'h0, (tmo ? "R6" : "R5")});
            if (!wr && !tmo)
                for (int k = last_of(len); k >= 0; k--)
                    expq.push_back('{1, 5'(8'h18 + k), 16'h0, "R7"});
        end
        busy_left = nbusy;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_page = pg; req_reg = rg;
        req_len = 4'(len); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        vectors++;
        if (busy !== legal)
            fail($sformatf("R9 busy after accept: actual %0b expected %0b", busy, legal));
        cyc = 0;
        while (!(done || err_tmo || err_len) && cyc < 3000) begin
            if (poke && cyc == 2) begin
                req_valid = 1'b1; req_len = 4'd3; req_page = 8'h77;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        vectors++;
        if (!legal) begin
            if (!err_len || done || err_tmo)
                fail($sformatf("R8 outcome: actual err_len=%0b done=%0b tmo=%0b expected err_len=1",
                               err_len, done, err_tmo));
        end else if (tmo) begin
            if (!err_tmo || done)
                fail($sformatf("R6 outcome: actual tmo=%0b done=%0b expected tmo=1", err_tmo, done));
        end else begin
            if (!done || err_tmo || err_len)
                fail($sformatf("R5 outcome: actual done=%0b tmo=%0b err_len=%0b expected done=1",
                               done, err_tmo, err_len));
        end
        vectors++;
        if (busy)
            fail("R9 busy at outcome: actual 1 expected 0");
        vectors++;
        if (!wr && legal && !tmo) begin
            exp_rd = {dregs[3], dregs[2], dregs[1], dregs[0]} & mask_of(len);
            if (rdata !== exp_rd)
                fail($sformatf("R7 rdata: actual %h expected %h", rdata, exp_rd));
        end else if (rdata !== prev_rd) begin
            fail($sformatf("R7 rdata changed without read: actual %h expected %h", rdata, prev_rd));
        end
        vectors++;
        if (expq.size() != 0) begin
            fail($sformatf("R1 missing transfers: actual %0d left expected 0", expq.size()));
            expq.delete();
        end
        @(negedge clk);
        vectors++;
        if (done || err_tmo || err_len || busy)
            fail($sformatf("R9 pulse width: actual done=%0b tmo=%0b len=%0b busy=%0b expected all 0",
                           done, err_tmo, err_len, busy));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fail("R9 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_page = '0;
        req_reg = '0; req_len = '0; req_wdata = '0;
        dregs[0] = 16'hBEEF; dregs[1] = 16'hCAFE; dregs[2] = 16'h1357; dregs[3] = 16'h2468;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (busy || done || err_len || err_tmo || mdio_req)
            fail($sformatf("R10 reset state: actual busy=%0b done=%0b len=%0b tmo=%0b req=%0b expected 0",
                           busy, done, err_len, err_tmo, mdio_req));
        // R10: page 0x00 first still needs a page write (cache invalid)
        run(0, 8'h00, 8'h30, 2, 64'h0, 2, 0);
        // R2: same page skips page write
        run(0, 8'h00, 8'h31, 4, 64'h0, 0, 0);
        // R3 / R9: 8-byte write with an ignored request while busy
        run(1, 8'h05, 8'h10, 8, 64'h1122334455667788, 1, 1);
        // R3: 1-byte write sends upper byte as zero
        run(1, 8'h05, 8'h18, 1, 64'hFFFF_FFFF_FFFF_FFA5, 0, 0);
        run(1, 8'h05, 8'h20, 6, 64'hDEAD_0102_0304_0506, 3, 0);
        // R7: read lengths
        run(0, 8'h05, 8'h40, 1, 64'h0, 0, 0);
        dregs[0] = 16'h0A0B; dregs[1] = 16'h0C0D; dregs[2] = 16'h0E0F; dregs[3] = 16'h8899;
        run(0, 8'h05, 8'h41, 6, 64'h0, 1, 0);
        run(0, 8'h05, 8'h42, 8, 64'h0, 0, 0);
        // R8: illegal lengths
        run(0, 8'h09, 8'h00, 3, 64'h0, 0, 0);
        run(1, 8'h09, 8'h00, 0, 64'h0, 0, 0);
        run(0, 8'h09, 8'h00, 9, 64'h0, 0, 0);
        // R6: timeout, page stays cached
        run(0, 8'h34, 8'h06, 4, 64'h0, 200, 0);
        run(1, 8'h34, 8'h08, 2, 64'hABCD_1234, 0, 0);
        run(1, 8'h02, 8'h0C, 4, 64'h5A5A_C3C3, 5, 0);
        summary();
        $finish;
    end
endmodule